// File: doc/BRIEF.md
# Speculative/Non-Speculative Memory Access Router

This block sits between two threads and their data storage: a speculative thread that runs ahead on predicted values, and a non-speculative thread that holds the architectural state. Both threads issue word loads and stores. The block decides which structure each access touches. The speculative thread writes only into a small private speculative cache. The non-speculative thread reads and writes a two-level non-speculative hierarchy: a direct-mapped first level in front of a second level that covers the whole address space.

Speculative loads prefer words the speculative thread has written. Any other speculative load reads the non-speculative hierarchy without disturbing it. When the prediction behind the speculative run turns out wrong, one pulse on an invalidate input discards every speculative line.

Requests enter on valid/ready channels. A requester raises valid with its fields and holds them unchanged until it sees ready high at a rising edge. The non-speculative channel is always ready. Load responses come back as one-cycle valid pulses with data and a source code. They cannot be back-pressured, so the requester must take each response in the cycle it appears. All caches are behavioural arrays inside the block.

Top module: `mem_route_top`

## Requirements
- R1: A non-speculative store allocates its line in the first-level non-speculative cache on a miss and writes the word there. A following non-speculative load of that word returns the stored value with source code 1.
- R2: A non-speculative load that misses the first level returns the second-level word with source code 2 and allocates the line, so the next non-speculative load of the same line returns source code 1.
- R3: When a first-level non-speculative line is replaced, all of its words are copied to the second level. A later non-speculative load of an evicted word returns the last stored value with source code 2.
- R4: A speculative store changes only the speculative cache, so non-speculative loads still see the older value. A speculative load of a word the speculative thread has written returns the speculative value even after a newer non-speculative store to it.
- R5: A speculative load of a word written by the speculative thread since the line was allocated returns that value with source code 0.
- R6: A speculative load of a word it has not written falls back to the non-speculative hierarchy. It returns the first-level word with source code 1 on a first-level hit, otherwise the second-level word with source code 2.
- R7: A speculative load that falls back allocates nothing in the first-level non-speculative cache. A following non-speculative load of that address still returns source code 2.
- R8: A one-cycle pulse on `spec_flush` invalidates every speculative line. Afterwards, speculative loads return non-speculative data.
- R9: When both threads present a request in the same cycle, the non-speculative one is accepted and `sp_req_ready` is low. `sp_req_ready` is also low while `spec_flush` is high. A held speculative request is accepted in the first cycle with neither condition.
- R10: A load accepted at a rising edge gives a response valid for exactly the following cycle. A store gives no response.
- R11: After reset both response valids are low and both request readies are high.
- R12: The speculative cache is direct mapped with 16 lines of 4 words. Word address bits [1:0] select the word and bits [5:2] the line. The first level is direct mapped with 8 lines of 4 words, line selected by bits [4:2]. A speculative store to a line slot held by a different address takes the slot, starts with only the stored word marked written, and the old speculative words then fall back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| spec_flush | input | 1 | Invalidate all speculative lines |
| ns_req_valid | input | 1 | Non-speculative request valid |
| ns_req_ready | output | 1 | Non-speculative request accepted (always high) |
| ns_req_store | input | 1 | 1 = store, 0 = load |
| ns_req_addr | input | 10 | Word address |
| ns_req_wdata | input | 32 | Store data |
| ns_rsp_valid | output | 1 | Non-speculative load response valid |
| ns_rsp_data | output | 32 | Load data |
| ns_rsp_src | output | 2 | 0 speculative cache, 1 first level, 2 second level |
| sp_req_valid | input | 1 | Speculative request valid |
| sp_req_ready | output | 1 | Speculative request accepted |
| sp_req_store | input | 1 | 1 = store, 0 = load |
| sp_req_addr | input | 10 | Word address |
| sp_req_wdata | input | 32 | Store data |
| sp_rsp_valid | output | 1 | Speculative load response valid |
| sp_rsp_data | output | 32 | Load data |
| sp_rsp_src | output | 2 | 0 speculative cache, 1 first level, 2 second level |

## Verification
A wrong tag, valid bit or written bit shows on the next load to that line, as a wrong source code or a stale data word in the response one cycle after acceptance. A lost write-back stays hidden until the evicted line is loaded again from the second level. The bench therefore evicts lines and reloads them. A speculative write that leaks into the non-speculative side, or a fallback that allocates, shows on the very next non-speculative load of that address.

// File: rtl/mem_route_pkg.sv
package mem_route_pkg;
  typedef enum logic [1:0] {
    SRC_SPEC = 2'd0,
    SRC_NL1  = 2'd1,
    SRC_NL2  = 2'd2
  } src_e;
endpackage

// File: rtl/mem_route_arb.sv
module mem_route_arb #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          ns_valid,
  input  logic          ns_store,
  input  logic [AW-1:0] ns_addr,
  input  logic [DW-1:0] ns_wdata,
  output logic          ns_ready,
  input  logic          sp_valid,
  input  logic          sp_store,
  input  logic [AW-1:0] sp_addr,
  input  logic [DW-1:0] sp_wdata,
  output logic          sp_ready,
  output logic          op_valid,
  output logic          op_spec,
  output logic          op_store,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_wdata
);
  assign ns_ready = 1'b1;
  assign sp_ready = !ns_valid && !flush;

  always_comb begin
    op_valid = ns_valid || (sp_valid && sp_ready);
    op_spec  = !ns_valid;
    if (ns_valid) begin
      op_store = ns_store;
      op_addr  = ns_addr;
      op_wdata = ns_wdata;
    end else begin
      op_store = sp_store;
      op_addr  = sp_addr;
      op_wdata = sp_wdata;
    end
  end

  // R9
  ns_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_valid && sp_valid) |-> (op_valid && !op_spec && op_addr == ns_addr));

  // R9
  flush_blocks_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !ns_valid) |-> !op_valid);
endmodule

// File: rtl/mem_route_spec_cache.sv
module mem_route_spec_cache #(
  parameter int AW   = 10,
  parameter int DW   = 32,
  parameter int SETS = 16,
  parameter int LW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          op_valid,
  input  logic          op_spec,
  input  logic          op_store,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  output logic          hit,
  output logic [DW-1:0] hit_data
);
  localparam int OFS_W = $clog2(LW);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = AW - IDX_W - OFS_W;

  logic [SETS-1:0]  vld;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [LW-1:0]    wbits [SETS];
  logic [DW-1:0]    dat   [SETS][LW];

  logic [OFS_W-1:0] ofs;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             line_match;
  logic             we;

  assign ofs = op_addr[OFS_W-1:0];
  assign idx = op_addr[OFS_W +: IDX_W];
  assign tag = op_addr[AW-1 -: TAG_W];

  assign line_match = vld[idx] && (tag_q[idx] == tag);
  assign hit        = line_match && wbits[idx][ofs];
  assign hit_data   = dat[idx][ofs];
  assign we         = op_valid && op_spec && op_store;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (flush) begin
      vld <= '0;
    end else if (we) begin
      vld[idx]   <= 1'b1;
      tag_q[idx] <= tag;
      if (line_match) wbits[idx][ofs] <= 1'b1;
      else            wbits[idx] <= LW'(1) << ofs;
    end
  end

  always_ff @(posedge clk) begin
    if (we) dat[idx][ofs] <= op_wdata;
  end

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0));

  // R12
  store_marks_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !flush) |=> (vld[$past(idx)] && wbits[$past(idx)][$past(ofs)]
                        && tag_q[$past(idx)] == $past(tag)));
endmodule

// File: rtl/mem_route_ns_hier.sv
module mem_route_ns_hier
  import mem_route_pkg::*;
#(
  parameter int AW   = 10,
  parameter int DW   = 32,
  parameter int SETS = 8,
  parameter int LW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic          op_spec,
  input  logic          op_store,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  output logic [DW-1:0] rd_data,
  output src_e          rd_src
);
  localparam int OFS_W = $clog2(LW);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = AW - IDX_W - OFS_W;
  localparam int DEPTH = 1 << AW;

  logic [SETS-1:0]  vld;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [DW-1:0]    l1    [SETS][LW];
  logic [DW-1:0]    l2    [DEPTH];

  logic [OFS_W-1:0] ofs;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             hit, ns_op, fill, wb, l1_we;
  logic [AW-1:0]    vic_base;
  logic [DW-1:0]    l1_vic0;

  assign ofs = op_addr[OFS_W-1:0];
  assign idx = op_addr[OFS_W +: IDX_W];
  assign tag = op_addr[AW-1 -: TAG_W];

  assign hit      = vld[idx] && (tag_q[idx] == tag);
  assign ns_op    = op_valid && !op_spec;
  assign fill     = ns_op && !hit;
  assign wb       = fill && vld[idx];
  assign l1_we    = ns_op && op_store;
  assign vic_base = {tag_q[idx], idx, {OFS_W{1'b0}}};
  assign l1_vic0  = l1[idx][0];

  always_comb begin
    if (hit) begin
      rd_data = l1[idx][ofs];
      rd_src  = SRC_NL1;
    end else begin
      rd_data = l2[op_addr];
      rd_src  = SRC_NL2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (fill) begin
      vld[idx]   <= 1'b1;
      tag_q[idx] <= tag;
    end
  end

  // line fill first; the store word written after it overrides its slot
  always_ff @(posedge clk) begin
    if (fill) begin
      for (int w = 0; w < LW; w++) l1[idx][w] <= l2[{tag, idx, OFS_W'(w)}];
    end
    if (l1_we) l1[idx][ofs] <= op_wdata;
  end

  always_ff @(posedge clk) begin
    if (wb) begin
      for (int w = 0; w < LW; w++) l2[{tag_q[idx], idx, OFS_W'(w)}] <= l1[idx][w];
    end
  end

  // R2
  fill_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> (vld[$past(idx)] && tag_q[$past(idx)] == $past(tag)));

  // R3
  victim_copied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb |=> (l2[$past(vic_base)] == $past(l1_vic0)));

  // R7
  spec_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_spec) |=> $stable(vld));

  // R4
  spec_no_l1_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_spec && hit) |=> (l1[$past(idx)][$past(ofs)] == $past(rd_data)));
endmodule

// File: rtl/mem_route_top.sv
module mem_route_top
  import mem_route_pkg::*;
#(
  parameter int AW      = 10,
  parameter int DW      = 32,
  parameter int LW      = 4,
  parameter int SP_SETS = 16,
  parameter int NS_SETS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spec_flush,
  input  logic          ns_req_valid,
  output logic          ns_req_ready,
  input  logic          ns_req_store,
  input  logic [AW-1:0] ns_req_addr,
  input  logic [DW-1:0] ns_req_wdata,
  output logic          ns_rsp_valid,
  output logic [DW-1:0] ns_rsp_data,
  output logic [1:0]    ns_rsp_src,
  input  logic          sp_req_valid,
  output logic          sp_req_ready,
  input  logic          sp_req_store,
  input  logic [AW-1:0] sp_req_addr,
  input  logic [DW-1:0] sp_req_wdata,
  output logic          sp_rsp_valid,
  output logic [DW-1:0] sp_rsp_data,
  output logic [1:0]    sp_rsp_src
);
  logic          op_valid, op_spec, op_store;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata;
  logic          sp_hit;
  logic [DW-1:0] sp_hit_data, ns_rd_data;
  src_e          ns_rd_src;
  logic          is_load;

  mem_route_arb #(.AW(AW), .DW(DW)) i_arb (
    .clk(clk), .rst_n(rst_n), .flush(spec_flush),
    .ns_valid(ns_req_valid), .ns_store(ns_req_store), .ns_addr(ns_req_addr),
    .ns_wdata(ns_req_wdata), .ns_ready(ns_req_ready),
    .sp_valid(sp_req_valid), .sp_store(sp_req_store), .sp_addr(sp_req_addr),
    .sp_wdata(sp_req_wdata), .sp_ready(sp_req_ready),
    .op_valid(op_valid), .op_spec(op_spec), .op_store(op_store),
    .op_addr(op_addr), .op_wdata(op_wdata)
  );

  mem_route_spec_cache #(.AW(AW), .DW(DW), .SETS(SP_SETS), .LW(LW)) i_spec (
    .clk(clk), .rst_n(rst_n), .flush(spec_flush),
    .op_valid(op_valid), .op_spec(op_spec), .op_store(op_store),
    .op_addr(op_addr), .op_wdata(op_wdata),
    .hit(sp_hit), .hit_data(sp_hit_data)
  );

  mem_route_ns_hier #(.AW(AW), .DW(DW), .SETS(NS_SETS), .LW(LW)) i_ns (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_spec(op_spec), .op_store(op_store),
    .op_addr(op_addr), .op_wdata(op_wdata),
    .rd_data(ns_rd_data), .rd_src(ns_rd_src)
  );

  assign is_load = op_valid && !op_store;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ns_rsp_valid <= 1'b0;
      sp_rsp_valid <= 1'b0;
      ns_rsp_data  <= '0;
      sp_rsp_data  <= '0;
      ns_rsp_src   <= '0;
      sp_rsp_src   <= '0;
    end else begin
      ns_rsp_valid <= is_load && !op_spec;
      sp_rsp_valid <= is_load && op_spec;
      if (is_load && !op_spec) begin
        ns_rsp_data <= ns_rd_data;
        ns_rsp_src  <= ns_rd_src;
      end
      if (is_load && op_spec) begin
        sp_rsp_data <= sp_hit ? sp_hit_data : ns_rd_data;
        sp_rsp_src  <= sp_hit ? SRC_SPEC : ns_rd_src;
      end
    end
  end

  // R10
  ns_load_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_req_valid && ns_req_ready && !ns_req_store) |=> ns_rsp_valid);

  // R10
  sp_load_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_req_valid && sp_req_ready && !sp_req_store) |=> sp_rsp_valid);

  // R10
  no_store_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_req_valid && ns_req_store) |=> !ns_rsp_valid);

  // R9
  one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ns_rsp_valid && sp_rsp_valid));
endmodule

// File: tb/test_mem_route_top.sv
`timescale 1ns/1ps
module test_mem_route_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, spec_flush;
  logic        ns_req_valid, ns_req_ready, ns_req_store;
  logic [9:0]  ns_req_addr;
  logic [31:0] ns_req_wdata;
  logic        ns_rsp_valid;
  logic [31:0] ns_rsp_data;
  logic [1:0]  ns_rsp_src;
  logic        sp_req_valid, sp_req_ready, sp_req_store;
  logic [9:0]  sp_req_addr;
  logic [31:0] sp_req_wdata;
  logic        sp_rsp_valid;
  logic [31:0] sp_rsp_data;
  logic [1:0]  sp_rsp_src;

  mem_route_top i_mem_route_top (.*);

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        sp;
    logic        st;
    logic [9:0]  a;
    logic [31:0] d;
    logic [1:0]  src;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    '{1'b0, 1'b1, 10'h004, 32'h1111_1111, 2'd0, 8'd1},   // R1 store, allocates
    '{1'b0, 1'b0, 10'h004, 32'h1111_1111, 2'd1, 8'd1},   // R1 hit
    '{1'b0, 1'b1, 10'h024, 32'h2222_2222, 2'd0, 8'd3},   // R3 evicts 0x004 line
    '{1'b0, 1'b0, 10'h004, 32'h1111_1111, 2'd2, 8'd3},   // R3 from second level
    '{1'b0, 1'b0, 10'h004, 32'h1111_1111, 2'd1, 8'd2},   // R2 now allocated
    '{1'b0, 1'b0, 10'h024, 32'h2222_2222, 2'd2, 8'd3},   // R3
    '{1'b1, 1'b1, 10'h004, 32'hAAAA_0001, 2'd0, 8'd4},   // R4 spec store
    '{1'b1, 1'b0, 10'h004, 32'hAAAA_0001, 2'd0, 8'd5},   // R5
    '{1'b0, 1'b0, 10'h004, 32'h1111_1111, 2'd2, 8'd4},   // R4 old value kept
    '{1'b0, 1'b1, 10'h005, 32'h5555_5555, 2'd0, 8'd1},   // R1 store hit
    '{1'b1, 1'b0, 10'h005, 32'h5555_5555, 2'd1, 8'd6},   // R6 unwritten word, first level
    '{1'b1, 1'b0, 10'h024, 32'h2222_2222, 2'd2, 8'd6},   // R6 second level
    '{1'b0, 1'b0, 10'h024, 32'h2222_2222, 2'd2, 8'd7},   // R7 no allocation by spec
    '{1'b1, 1'b1, 10'h044, 32'hBBBB_0002, 2'd0, 8'd12},  // R12 takes slot of 0x004
    '{1'b1, 1'b0, 10'h004, 32'h1111_1111, 2'd2, 8'd12},  // R12 old word falls back
    '{1'b0, 1'b1, 10'h044, 32'h4444_4444, 2'd0, 8'd4},   // R4 newer ns store
    '{1'b1, 1'b0, 10'h044, 32'hBBBB_0002, 2'd0, 8'd4},   // R4 spec value wins
    '{1'b0, 1'b0, 10'h005, 32'h5555_5555, 2'd2, 8'd3}    // R3 written-back word
  };

  task automatic idle_inputs();
    ns_req_valid = 1'b0; ns_req_store = 1'b0; ns_req_addr = '0; ns_req_wdata = '0;
    sp_req_valid = 1'b0; sp_req_store = 1'b0; sp_req_addr = '0; sp_req_wdata = '0;
    spec_flush = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    string r;
    r = $sformatf("R%0d", v.req);
    @(negedge clk);
    if (v.sp) begin
      sp_req_valid = 1'b1; sp_req_store = v.st; sp_req_addr = v.a; sp_req_wdata = v.d;
    end else begin
      ns_req_valid = 1'b1; ns_req_store = v.st; ns_req_addr = v.a; ns_req_wdata = v.d;
    end
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    if (v.st) begin
      // R10 no response to a store
      chk(!ns_rsp_valid && !sp_rsp_valid, "R10", {ns_rsp_valid, sp_rsp_valid}, 0);
    end else if (v.sp) begin
      chk(sp_rsp_valid && !ns_rsp_valid && sp_rsp_src == v.src && sp_rsp_data == v.d, r,
          {ns_rsp_valid, sp_rsp_valid, sp_rsp_src, sp_rsp_data}, {2'b01, v.src, v.d});
    end else begin
      chk(ns_rsp_valid && !sp_rsp_valid && ns_rsp_src == v.src && ns_rsp_data == v.d, r,
          {sp_rsp_valid, ns_rsp_valid, ns_rsp_src, ns_rsp_data}, {2'b01, v.src, v.d});
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk(!ns_rsp_valid && !sp_rsp_valid && ns_req_ready && sp_req_ready, "R11",
        {ns_rsp_valid, sp_rsp_valid, ns_req_ready, sp_req_ready}, 4'b0011);

    for (int i = 0; i < NV; i++) run_vec(VT[i]);

    // R10 response lasts one cycle only
    @(negedge clk);
    chk(!ns_rsp_valid && !sp_rsp_valid, "R10", {ns_rsp_valid, sp_rsp_valid}, 0);

    // R9 flush holds off a speculative request
    spec_flush = 1'b1;
    sp_req_valid = 1'b1; sp_req_store = 1'b0; sp_req_addr = 10'h044;
    #1;
    chk(!sp_req_ready, "R9", sp_req_ready, 0);
    @(posedge clk);
    @(negedge clk);
    spec_flush = 1'b0;
    chk(!sp_rsp_valid, "R9", sp_rsp_valid, 0);
    @(posedge clk);
    @(negedge clk);
    sp_req_valid = 1'b0;
    // R8 speculative value gone; written-back ns value from second level
    chk(sp_rsp_valid && sp_rsp_src == 2'd2 && sp_rsp_data == 32'h4444_4444, "R8",
        {sp_rsp_valid, sp_rsp_src, sp_rsp_data}, {1'b1, 2'd2, 32'h4444_4444});

    // R9 simultaneous requests: ns first, spec one cycle later
    @(negedge clk);
    ns_req_valid = 1'b1; ns_req_store = 1'b0; ns_req_addr = 10'h004;
    sp_req_valid = 1'b1; sp_req_store = 1'b0; sp_req_addr = 10'h044;
    #1;
    chk(!sp_req_ready && ns_req_ready, "R9", {ns_req_ready, sp_req_ready}, 2'b10);
    @(posedge clk);
    @(negedge clk);
    ns_req_valid = 1'b0;
    chk(ns_rsp_valid && !sp_rsp_valid && ns_rsp_src == 2'd1 && ns_rsp_data == 32'h1111_1111, "R9",
        {sp_rsp_valid, ns_rsp_valid, ns_rsp_src, ns_rsp_data}, {2'b01, 2'd1, 32'h1111_1111});
    #1;
    chk(sp_req_ready, "R9", sp_req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    sp_req_valid = 1'b0;
    chk(sp_rsp_valid && !ns_rsp_valid && sp_rsp_src == 2'd2 && sp_rsp_data == 32'h4444_4444, "R9",
        {ns_rsp_valid, sp_rsp_valid, sp_rsp_src, sp_rsp_data}, {2'b01, 2'd2, 32'h4444_4444});

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule